// File: doc/BRIEF.md
# Dual-PWM 16-bit Audio DAC

This block turns a stream of signed 16-bit audio words into a pair of pulse-width-modulated pins. A resistor network outside the chip weights and sums them into one analog level. A single free-running counter feeds two compare channels. The coarse channel carries the upper eight bits of the sample, raised by a fixed offset. The fine channel carries the lower eight bits. Each pin goes high when the counter wraps and falls when the counter reaches that channel's compare value.

A producer offers samples on a valid/ready handshake. An accepted word waits in a one-entry holding slot. At the end of every second PWM period, the held word's compare pair replaces the active pair, and both halves change together. If nothing is held at that moment, a mid-scale silence pair is applied instead. The same pair is applied from reset until the first sample arrives. A one-cycle request strobe, timed on the coarse channel's compare match, tells the producer that the next sample is due.

Top module: `dpwm_audio_dac`

## Requirements
- R1: The counter runs from 0 to 543 and wraps, so both pins repeat with a period of 544 clocks, and the coarse pin rises in the cycle in which the counter is 0.
- R2: A sample s is mapped through u = s XOR 0x8000. The coarse compare value is u[15:8] + 120 and the fine compare value is u[7:0]. Each pin is high for exactly its compare value in clocks, starting at count 0, and is low in the last cycle of each period.
- R3: The coarse compare value stays between 120 and 375. Sample 0x8000 gives 120 and sample 0x7FFF gives 375, so it is never 0.
- R4: A compare pair stays in force for two whole periods. The active pair changes only at the wrap that ends the second period of a pair.
- R5: When the holding slot is empty at a pair boundary, the pair (coarse 248, fine 0) is applied. The same pair is active for the first two periods after reset.
- R6: sample_req pulses for one clock, once per pair, in the first period of the pair, in the cycle in which the counter equals the active coarse compare value.
- R7: in_ready is high when the holding slot is empty or in the last cycle of a pair. In any other cycle it is low. A word accepted in the last cycle of a pair does not take part in that boundary: the word held before it is applied, and the new word is applied at the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 16 | Signed audio sample |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | The offered sample is taken at this edge |
| pwm_hi | output | 1 | Coarse (upper byte) PWM pin |
| pwm_lo | output | 1 | Fine (lower byte) PWM pin |
| sample_req | output | 1 | One-cycle request for the next sample |

## Verification
The handshake and the pair boundary can fall in the same cycle. In that cycle the holding slot is emptied into the active pair, and a new word may be written into it. Directed offers are placed in the last cycle of a pair twice: once with the slot full, where the held word must be applied and the new one kept for the next pair, and once with the slot empty, where silence must be applied first. The outcome is judged from in_ready in that cycle and from the measured high-times of both pins over the next two pairs.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   localparam int DPWM_CMP_W = 10;

   typedef struct packed {
      logic [DPWM_CMP_W-1:0] hi;
      logic [DPWM_CMP_W-1:0] lo;
   } dpwm_pair_t;
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
   parameter int PERIOD = 544,
   parameter int REPEAT = 2,
   localparam int CNT_W = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             pair_end,
   output logic             first_period
);
   assign wrap = (cnt == CNT_W'(PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= wrap ? '0 : cnt + 1'b1;
   end

   generate
      if (REPEAT > 1) begin : g_multi
         localparam int RW = $clog2(REPEAT);
         logic [RW-1:0] rep;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rep <= '0;
            else if (wrap) rep <= (rep == RW'(REPEAT - 1)) ? '0 : rep + 1'b1;
         end
         assign pair_end     = wrap && (rep == RW'(REPEAT - 1));
         assign first_period = (rep == '0);
      end else begin : g_single
         assign pair_end     = wrap;
         assign first_period = 1'b1;
      end
   endgenerate

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0)); // R1
endmodule

// File: rtl/dpwm_encoder.sv
module dpwm_encoder
   import dpwm_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int HALF_W    = 8,
   parameter int HI_OFFSET = 120
) (
   input  logic [SAMPLE_W-1:0] sample,
   output dpwm_pair_t          pair
);
   logic [SAMPLE_W-1:0] ofs;

   assign ofs     = sample ^ {1'b1, {(SAMPLE_W-1){1'b0}}};
   assign pair.hi = DPWM_CMP_W'(ofs[SAMPLE_W-1 -: HALF_W]) + DPWM_CMP_W'(HI_OFFSET);
   assign pair.lo = DPWM_CMP_W'(ofs[HALF_W-1:0]);
endmodule

// File: rtl/dpwm_slot.sv
module dpwm_slot
   import dpwm_pkg::*;
#(
   parameter int HALF_W    = 8,
   parameter int HI_OFFSET = 120,
   parameter int SIL_HI    = 248,
   parameter int SIL_LO    = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  dpwm_pair_t in_pair,
   input  logic       in_valid,
   input  logic       pair_end,
   output logic       in_ready,
   output dpwm_pair_t act
);
   localparam dpwm_pair_t SILENCE = '{hi: DPWM_CMP_W'(SIL_HI), lo: DPWM_CMP_W'(SIL_LO)};

   dpwm_pair_t pend;
   logic       pend_v;
   logic       accept;

   assign in_ready = !pend_v || pair_end;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= SILENCE;
         pend   <= SILENCE;
         pend_v <= 1'b0;
      end else begin
         if (pair_end) begin
            act    <= pend_v ? pend : SILENCE;
            pend_v <= accept;
         end else if (accept) begin
            pend_v <= 1'b1;
         end
         if (accept) pend <= in_pair;
      end
   end

   AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_end |=> $stable(act)); // R4
   AST_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (act.hi >= DPWM_CMP_W'(HI_OFFSET)) &&
      (act.hi <= DPWM_CMP_W'(HI_OFFSET + (1 << HALF_W) - 1))); // R3
   AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && !pair_end) |=> pend_v); // R7
endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare
   import dpwm_pkg::*;
#(
   parameter int N_CH = 2
) (
   input  logic [DPWM_CMP_W-1:0]           cnt,
   input  logic [N_CH-1:0][DPWM_CMP_W-1:0] cmp,
   output logic [N_CH-1:0]                 pwm
);
   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         assign pwm[g] = (cnt < cmp[g]);
      end
   endgenerate
endmodule

// File: rtl/dpwm_audio_dac.sv
module dpwm_audio_dac
   import dpwm_pkg::*;
#(
   parameter int PERIOD    = 544,
   parameter int REPEAT    = 2,
   parameter int SAMPLE_W  = 16,
   parameter int HALF_W    = 8,
   parameter int HI_OFFSET = 120,
   parameter int SIL_HI    = 248,
   parameter int SIL_LO    = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] in_data,
   input  logic                in_valid,
   output logic                in_ready,
   output logic                pwm_hi,
   output logic                pwm_lo,
   output logic                sample_req
);
   localparam int CNT_W = $clog2(PERIOD);

   generate
      if (SAMPLE_W != 2 * HALF_W) begin : g_chk_split
         $error("sample width must be twice the half width");
      end
      if (HI_OFFSET < 1) begin : g_chk_ofs
         $error("coarse offset must keep the compare value above zero");
      end
      if (HI_OFFSET + (1 << HALF_W) - 1 >= PERIOD) begin : g_chk_range
         $error("coarse compare range exceeds the period");
      end
      if (CNT_W > DPWM_CMP_W) begin : g_chk_cw
         $error("period does not fit the compare width");
      end
      if (REPEAT < 1) begin : g_chk_rep
         $error("repeat count must be at least one");
      end
   endgenerate

   logic [CNT_W-1:0]      cnt;
   logic [DPWM_CMP_W-1:0] cnt_ext;
   logic                  wrap, pair_end, first_period;
   dpwm_pair_t            in_pair, act;
   logic [1:0]            pwm;

   dpwm_timebase #(.PERIOD(PERIOD), .REPEAT(REPEAT)) u_tb (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap),
      .pair_end(pair_end), .first_period(first_period)
   );

   dpwm_encoder #(.SAMPLE_W(SAMPLE_W), .HALF_W(HALF_W), .HI_OFFSET(HI_OFFSET)) u_enc (
      .sample(in_data), .pair(in_pair)
   );

   dpwm_slot #(.HALF_W(HALF_W), .HI_OFFSET(HI_OFFSET), .SIL_HI(SIL_HI), .SIL_LO(SIL_LO)) u_slot (
      .clk(clk), .rst_n(rst_n), .in_pair(in_pair), .in_valid(in_valid),
      .pair_end(pair_end), .in_ready(in_ready), .act(act)
   );

   assign cnt_ext = DPWM_CMP_W'(cnt);

   dpwm_compare #(.N_CH(2)) u_cmp (
      .cnt(cnt_ext), .cmp({act.hi, act.lo}), .pwm(pwm)
   );

   assign pwm_hi     = pwm[1];
   assign pwm_lo     = pwm[0];
   assign sample_req = first_period && (cnt_ext == act.hi);

   AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> (!pwm_hi && !pwm_lo)); // R2
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |=> !sample_req); // R6
endmodule

// File: tb/test_dpwm_audio_dac.sv
module test_dpwm_audio_dac;
   localparam int PER   = 544;
   localparam int SLEN  = 2 * PER;
   localparam int SLOTS = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready, pwm_hi, pwm_lo, sample_req;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   dpwm_audio_dac i_dpwm_audio_dac (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .sample_req(sample_req)
   );

   function automatic int map_hi(logic [15:0] s);
      logic [15:0] u = s ^ 16'h8000;
      return int'(u[15:8]) + 120;
   endfunction

   function automatic int map_lo(logic [15:0] s);
      logic [15:0] u = s ^ 16'h8000;
      return int'(u[7:0]);
   endfunction

   task automatic chk(bit ok, string req, int act_v, int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   int          off1 [SLOTS];
   int          off2 [SLOTS];
   logic [15:0] s1 [SLOTS];
   logic [15:0] s2 [SLOTS];

   initial begin
      int cur_hi, cur_lo, nxt_hi, nxt_lo, hc, lc;
      bit cur_sil, nxt_sil, p_has, prev_hi;
      logic [15:0] p_val;
      void'($urandom(32'h0000_5eed));
      for (int s = 0; s < SLOTS; s++) begin
         int mode = int'($urandom_range(0, 3));
         off1[s] = -1; off2[s] = -1;
         s1[s] = 16'($urandom); s2[s] = 16'($urandom);
         if (mode == 1 || mode == 2) off1[s] = int'($urandom_range(0, SLEN - 1));
         if (mode == 3) begin
            off1[s] = int'($urandom_range(0, 1000));
            off2[s] = int'($urandom_range(off1[s] + 1, SLEN - 1));
         end
      end
      // directed corners
      off1[1] = 10;   s1[1] = 16'h8000; off2[1] = -1;      // R3 minimum
      off1[2] = -1;   off2[2] = -1;                         // R5 silence slot
      off1[3] = 100;  s1[3] = 16'h7FFF; off2[3] = SLEN - 1; s2[3] = 16'h1357; // R7 full + boundary
      off1[5] = -1;   off2[5] = -1;
      off1[6] = -1;   off2[6] = SLEN - 1; s2[6] = 16'h0000; // R7 empty + boundary
      off1[7] = -1;   off2[7] = -1;
      off1[9] = 500;  s1[9] = 16'h1234; off2[9] = 600; s2[9] = 16'hABCD; // R7 back-pressure

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // reset state: silence, count 0
      chk(pwm_hi == 1'b1, "R5 reset pwm_hi", int'(pwm_hi), 1);
      chk(pwm_lo == 1'b0, "R5 reset pwm_lo", int'(pwm_lo), 0);
      chk(sample_req == 1'b0, "R6 reset sample_req", int'(sample_req), 0);
      chk(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);

      cur_hi = 248; cur_lo = 0; cur_sil = 1'b1;
      nxt_hi = 248; nxt_lo = 0; nxt_sil = 1'b1;
      p_has = 1'b0; p_val = '0; hc = 0; lc = 0; prev_hi = 1'b0;

      for (int j = 0; j < SLOTS * SLEN; j++) begin
         int ph, sl, so;
         bit first, bound, offer, acc, exp_req;
         logic [15:0] d;
         if (j > 0) @(negedge clk);
         ph = j % PER; sl = j / SLEN; so = j % SLEN;
         first = (so < PER);
         bound = (so == SLEN - 1);

         if (pwm_hi) hc++;
         if (pwm_lo) lc++;
         if (pwm_hi && !prev_hi) chk(ph == 0, "R1 coarse rise at count 0", ph, 0);
         prev_hi = pwm_hi;

         exp_req = first && (ph == cur_hi);
         if (exp_req || sample_req)
            chk(sample_req == exp_req, "R6 sample_req", int'(sample_req), int'(exp_req));

         offer = (so == off1[sl]) || (so == off2[sl]);
         d = (so == off1[sl]) ? s1[sl] : s2[sl];
         if (offer)
            chk(in_ready == (!p_has || bound), "R7 in_ready", int'(in_ready), int'(!p_has || bound));
         in_valid = offer;
         in_data  = d;
         acc = offer && in_ready;

         if (bound) begin
            nxt_sil = !p_has;
            nxt_hi  = p_has ? map_hi(p_val) : 248;
            nxt_lo  = p_has ? map_lo(p_val) : 0;
            p_has   = 1'b0;
         end
         if (acc) begin
            p_has = 1'b1;
            p_val = d;
         end

         if (ph == PER - 1) begin
            if (cur_sil)                         chk(hc == cur_hi, "R5 silence coarse", hc, cur_hi);
            else if (!first)                     chk(hc == cur_hi, "R4 held coarse", hc, cur_hi);
            else if (cur_hi == 120 || cur_hi == 375) chk(hc == cur_hi, "R3 coarse extreme", hc, cur_hi);
            else                                 chk(hc == cur_hi, "R2 coarse", hc, cur_hi);
            chk(lc == cur_lo, "R2 fine", lc, cur_lo);
            hc = 0; lc = 0;
         end
         if (bound) begin
            cur_hi = nxt_hi; cur_lo = nxt_lo; cur_sil = nxt_sil;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule